// File: doc/BRIEF.md
# Accumulator Move and Return Execute Stage

This block is the execute stage for a subset of a small 8-bit accumulator machine. It receives one decoded instruction at a time: an opcode, a 6-bit register index, a one-bit destination select and an 8-bit literal, qualified by a valid strobe. It holds the machine state that these instructions touch:

- the accumulator;
- a file of 64 eight-bit registers;
- the zero flag;
- an option register;
- the global interrupt enable bit;
- an 8-deep stack of 10-bit return addresses.

The supported operations are:

- copying the accumulator into a register;
- loading a literal into the accumulator;
- moving a register either to the accumulator or back onto itself, which updates the zero flag in both cases;
- copying the accumulator into the option register;
- doing nothing;
- returning from an interrupt.

The return pops the stack and hands the address to the program counter through a one-cycle load strobe. It also sets the interrupt enable bit, and it occupies two cycles. During the second cycle `busy` is high and the stage accepts no instruction. The interrupt entry logic fills the stack through a push port, and a read port exposes the register file.

Top module: `acc_exec`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), the following are all 0: acc_o, opt_o, zero_o, gie_o, busy and pc_load. The stack pointer is also 0.
- R2: Opcode 1 (acc to register), when accepted, writes acc_o into register in_reg. acc_o, zero_o, opt_o and gie_o are unchanged.
- R3: Opcode 2 (load literal), when accepted, makes acc_o equal to in_imm after the edge. zero_o is unchanged.
- R4: Opcode 3 (register move) with in_dest 0 copies register in_reg into acc_o. zero_o becomes 1 exactly when the moved value is 0.
- R5: Opcode 3 with in_dest 1 leaves register in_reg and acc_o unchanged. zero_o still becomes 1 exactly when the register value is 0.
- R6: Opcode 4 (option load), when accepted, copies acc_o into opt_o. zero_o is unchanged.
- R7: Opcode 0, and the unused codes 6 and 7, change no state and keep busy low.
- R8: Opcode 5 (return) raises busy for the cycle after the accepting edge. At the next edge, pc_load is high for one cycle, pc_val holds the popped address and gie_o becomes 1.
- R9: An instruction presented while busy is high has no effect on any state.
- R10: push_en stores push_pc on top of the stack, and pops return entries last-in first-out. A push at the same edge as an accepted return is dropped.
- R11: The stack pointer wraps modulo 8. A pop with the pointer at 0 returns slot 7 and leaves the pointer at 7.
- R12: With in_valid low, no instruction takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Instruction valid |
| in_op | input | 3 | Opcode (0 nop, 1 acc to reg, 2 literal, 3 reg move, 4 option load, 5 return) |
| in_reg | input | 6 | Register index |
| in_dest | input | 1 | Register move destination: 0 accumulator, 1 register |
| in_imm | input | 8 | Literal for opcode 2 |
| push_en | input | 1 | Push a return address |
| push_pc | input | 10 | Return address to push |
| dbg_addr | input | 6 | Register file read index |
| dbg_data | output | 8 | Register file read data (combinational) |
| busy | output | 1 | Second cycle of a return in progress |
| pc_load | output | 1 | One-cycle program counter load strobe |
| pc_val | output | 10 | Address to load into the program counter |
| acc_o | output | 8 | Accumulator |
| opt_o | output | 8 | Option register |
| zero_o | output | 1 | Zero flag |
| gie_o | output | 1 | Global interrupt enable |

## Verification
The assertions assume that in_op, in_valid and in_dest are known at every clock edge after reset. They also assume that an instruction counts as accepted only when in_valid is high and busy is low. They do not assume that stack entries are initialised, so no property reads the stack contents. The bench drives inputs only at the falling edge. Before it issues any instruction, it fills every register with a literal and every stack slot with a push. It then draws random opcodes, including the unused codes and instructions deliberately presented while busy, so that each property is exercised on defined values.

// File: rtl/accx_pkg.sv
// Package: shared sizes and opcode type for the accumulator execute stage.
// Assumes: opcodes arrive already decoded as a 3-bit code.
package accx_pkg;
    parameter int DATA_W    = 8;
    parameter int NREGS     = 64;
    parameter int PC_W      = 10;
    parameter int STK_DEPTH = 8;

    typedef enum logic [2:0] {
        OP_NOP     = 3'd0,
        OP_ACC2REG = 3'd1,
        OP_LDIMM   = 3'd2,
        OP_REGMOV  = 3'd3,
        OP_LDOPT   = 3'd4,
        OP_RETI    = 3'd5
    } acc_op_e;

    typedef enum logic {
        ST_RUN  = 1'b0,
        ST_RET2 = 1'b1
    } exec_st_e;
endpackage

// File: rtl/accx_regfile.sv
// Module: register file with one write port, one execute read port and one
// observation read port. Both reads are combinational.
// Assumes: contents are not reset; the user initialises them.
module accx_regfile #(
    parameter int DW    = accx_pkg::DATA_W,
    parameter int NREGS = accx_pkg::NREGS,
    localparam int AW   = $clog2(NREGS)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] wa,
    input  logic [DW-1:0] wd,
    input  logic [AW-1:0] ra,
    output logic [DW-1:0] rd,
    input  logic [AW-1:0] oa,
    output logic [DW-1:0] od
);
    logic [DW-1:0] mem [NREGS];

    // Write the addressed entry on an enabled edge.
    always_ff @(posedge clk) begin
        if (we) mem[wa] <= wd;
    end

    // Combinational reads for the execute path and the observation port.
    always_comb begin
        rd = mem[ra];
        od = mem[oa];
    end
endmodule

// File: rtl/accx_retstack.sv
// Module: circular return-address stack. A push writes the slot at the
// pointer and advances it; a pop steps the pointer back and reads that slot.
// The pointer wraps modulo DEPTH, so there is no overflow or underflow state.
// Assumes: pop has priority; a push at the same edge is dropped.
module accx_retstack #(
    parameter int AW    = accx_pkg::PC_W,
    parameter int DEPTH = accx_pkg::STK_DEPTH,
    localparam int PW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [AW-1:0] push_d,
    input  logic          pop,
    output logic [AW-1:0] top
);
    logic [AW-1:0] slots [DEPTH];
    logic [PW-1:0] sp;
    logic [PW-1:0] sp_dec;

    // Pointer of the entry a pop would return.
    always_comb sp_dec = sp - PW'(1);

    // Top-of-stack value as seen by a pop this cycle.
    always_comb top = slots[sp_dec];

    // Pointer update: pop steps back, push steps forward, pop wins.
    always_ff @(posedge clk) begin
        if (!rst_n)    sp <= '0;
        else if (pop)  sp <= sp_dec;
        else if (push) sp <= sp + PW'(1);
    end

    // Slot write on a push that is not overridden by a pop.
    always_ff @(posedge clk) begin
        if (push && !pop) slots[sp] <= push_d;
    end
endmodule

// File: rtl/accx_ctrl.sv
// Module: execute control. Decodes the accepted opcode, owns the accumulator,
// option register, zero flag, interrupt enable and the two-cycle return
// sequence, and drives the register file write and the stack pop.
// Assumes: rf_rd is the combinational read of register in_reg.
module accx_ctrl
    import accx_pkg::*;
#(
    parameter int DW  = accx_pkg::DATA_W,
    parameter int RAW = $clog2(accx_pkg::NREGS),
    parameter int PCW = accx_pkg::PC_W
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           in_valid,
    input  logic [2:0]     in_op,
    input  logic [RAW-1:0] in_reg,
    input  logic           in_dest,
    input  logic [DW-1:0]  in_imm,
    input  logic [DW-1:0]  rf_rd,
    output logic           rf_we,
    output logic [RAW-1:0] rf_wa,
    output logic [DW-1:0]  rf_wd,
    output logic           stk_pop,
    input  logic [PCW-1:0] stk_top,
    output logic           busy,
    output logic           pc_load,
    output logic [PCW-1:0] pc_val,
    output logic [DW-1:0]  acc_o,
    output logic [DW-1:0]  opt_o,
    output logic           zero_o,
    output logic           gie_o
);
    exec_st_e st;
    acc_op_e  op;
    logic     accept;

    // Acceptance and opcode typing.
    always_comb begin
        busy   = (st == ST_RET2);
        accept = in_valid && !busy;
        op     = acc_op_e'(in_op);
    end

    // Register file write request and stack pop request.
    always_comb begin
        rf_wa   = in_reg;
        rf_we   = 1'b0;
        rf_wd   = acc_o;
        stk_pop = 1'b0;
        if (accept) begin
            unique case (op)
                OP_ACC2REG: rf_we = 1'b1;
                OP_REGMOV: begin
                    rf_we = in_dest;
                    rf_wd = rf_rd;
                end
                OP_RETI:   stk_pop = 1'b1;
                default:   ;
            endcase
        end
    end

    // Return sequencer: first edge pops, second edge loads the PC.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= ST_RUN;
            pc_load <= 1'b0;
            pc_val  <= '0;
            gie_o   <= 1'b0;
        end else begin
            pc_load <= 1'b0;
            if (st == ST_RET2) begin
                st      <= ST_RUN;
                pc_load <= 1'b1;
                gie_o   <= 1'b1;
            end else if (accept && op == OP_RETI) begin
                st     <= ST_RET2;
                pc_val <= stk_top;
            end
        end
    end

    // Accumulator, option register and zero flag updates.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_o  <= '0;
            opt_o  <= '0;
            zero_o <= 1'b0;
        end else if (accept) begin
            unique case (op)
                OP_LDIMM: acc_o <= in_imm;
                OP_LDOPT: opt_o <= acc_o;
                OP_REGMOV: begin
                    zero_o <= (rf_rd == '0);
                    if (!in_dest) acc_o <= rf_rd;
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/acc_exec.sv
// Module: top of the accumulator move and return execute stage. Connects the
// control, the register file and the return stack.
// Assumes: one decoded instruction per cycle while busy is low.
module acc_exec #(
    parameter int DW    = accx_pkg::DATA_W,
    parameter int NREGS = accx_pkg::NREGS,
    parameter int PCW   = accx_pkg::PC_W,
    parameter int DEPTH = accx_pkg::STK_DEPTH,
    localparam int RAW  = $clog2(NREGS)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           in_valid,
    input  logic [2:0]     in_op,
    input  logic [RAW-1:0] in_reg,
    input  logic           in_dest,
    input  logic [DW-1:0]  in_imm,
    input  logic           push_en,
    input  logic [PCW-1:0] push_pc,
    input  logic [RAW-1:0] dbg_addr,
    output logic [DW-1:0]  dbg_data,
    output logic           busy,
    output logic           pc_load,
    output logic [PCW-1:0] pc_val,
    output logic [DW-1:0]  acc_o,
    output logic [DW-1:0]  opt_o,
    output logic           zero_o,
    output logic           gie_o
);
    logic           rf_we;
    logic [RAW-1:0] rf_wa;
    logic [DW-1:0]  rf_wd;
    logic [DW-1:0]  rf_rd;
    logic           stk_pop;
    logic [PCW-1:0] stk_top;

    accx_ctrl #(.DW(DW), .RAW(RAW), .PCW(PCW)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
        .in_reg(in_reg), .in_dest(in_dest), .in_imm(in_imm), .rf_rd(rf_rd),
        .rf_we(rf_we), .rf_wa(rf_wa), .rf_wd(rf_wd), .stk_pop(stk_pop),
        .stk_top(stk_top), .busy(busy), .pc_load(pc_load), .pc_val(pc_val),
        .acc_o(acc_o), .opt_o(opt_o), .zero_o(zero_o), .gie_o(gie_o)
    );

    accx_regfile #(.DW(DW), .NREGS(NREGS)) u_rf (
        .clk(clk), .we(rf_we), .wa(rf_wa), .wd(rf_wd),
        .ra(in_reg), .rd(rf_rd), .oa(dbg_addr), .od(dbg_data)
    );

    accx_retstack #(.AW(PCW), .DEPTH(DEPTH)) u_stk (
        .clk(clk), .rst_n(rst_n), .push(push_en), .push_d(push_pc),
        .pop(stk_pop), .top(stk_top)
    );
endmodule

// File: rtl/accx_chk.sv
// Module: property checker for acc_exec, attached by bind.
// Assumes: inputs are known at every edge after reset.
module accx_chk #(
    parameter int DW = accx_pkg::DATA_W
) (
    input logic          clk,
    input logic          rst_n,
    input logic          in_valid,
    input logic [2:0]    in_op,
    input logic [DW-1:0] in_imm,
    input logic          busy,
    input logic          pc_load,
    input logic [DW-1:0] acc_o,
    input logic [DW-1:0] opt_o,
    input logic          zero_o,
    input logic          gie_o
);
    logic acc_ok;
    always_comb acc_ok = in_valid && !busy;

    // R8: an accepted return makes the stage busy on the next cycle.
    a_r8_reti_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_ok && in_op == 3'd5) |=> busy);

    // R8: the busy cycle is followed by a PC load with interrupts enabled.
    a_r8_pc_load: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (pc_load && gie_o && !busy));

    // R9: nothing in the accumulator or option register moves during busy.
    a_r9_busy_hold: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ($stable(acc_o) && $stable(opt_o) && $stable(zero_o)));

    // R3: a literal load lands in the accumulator.
    a_r3_literal: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_ok && in_op == 3'd2) |=> (acc_o == $past(in_imm)));

    // R6: an option load copies the accumulator.
    a_r6_option: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_ok && in_op == 3'd4) |=> (opt_o == $past(acc_o)));

    // R2: only a register move can alter the zero flag.
    a_r2_zero_kept: assert property (@(posedge clk) disable iff (!rst_n)
        !(acc_ok && in_op == 3'd3) |=> $stable(zero_o));

    // R8: pc_load never overlaps busy.
    a_r8_load_excl: assert property (@(posedge clk) disable iff (!rst_n)
        pc_load |-> !busy);
endmodule

bind acc_exec accx_chk #(.DW(DW)) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
    .in_imm(in_imm), .busy(busy), .pc_load(pc_load), .acc_o(acc_o),
    .opt_o(opt_o), .zero_o(zero_o), .gie_o(gie_o)
);

// File: tb/sim_acc_exec.sv
// Bench: directed set-up and corner cases, then seeded random instructions,
// compared at each falling edge with a reference model held in bench state.
module sim_acc_exec;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [2:0] in_op = '0;
    logic [5:0] in_reg = '0;
    logic       in_dest = 1'b0;
    logic [7:0] in_imm = '0;
    logic       push_en = 1'b0;
    logic [9:0] push_pc = '0;
    logic [5:0] dbg_addr = '0;
    logic [7:0] dbg_data;
    logic       busy, pc_load, zero_o, gie_o;
    logic [9:0] pc_val;
    logic [7:0] acc_o, opt_o;

    int n_chk = 0;
    int n_fail = 0;

    // Reference model state.
    logic [7:0] m_acc, m_opt;
    logic       m_z, m_gie, m_busy, m_load;
    logic [9:0] m_pcv;
    logic [7:0] m_rf [64];
    logic [9:0] m_stk [8];
    logic [2:0] m_sp;

    always #2.5 clk = ~clk;

    acc_exec u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
        .in_reg(in_reg), .in_dest(in_dest), .in_imm(in_imm),
        .push_en(push_en), .push_pc(push_pc), .dbg_addr(dbg_addr),
        .dbg_data(dbg_data), .busy(busy), .pc_load(pc_load), .pc_val(pc_val),
        .acc_o(acc_o), .opt_o(opt_o), .zero_o(zero_o), .gie_o(gie_o)
    );

    task automatic chk(string req, string what, int act, int exp_v);
        n_chk++;
        if (act !== exp_v) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp_v);
        end
    endtask

    function automatic string tag_of(logic v, logic bz, logic [2:0] op, logic d);
        if (!v) return "R12";
        if (bz) return "R9";
        case (op)
            3'd1: return "R2";
            3'd2: return "R3";
            3'd3: return d ? "R5" : "R4";
            3'd4: return "R6";
            3'd5: return "R8";
            default: return "R7";
        endcase
    endfunction

    // Model one edge with the currently driven inputs.
    task automatic model_edge();
        logic acc_in;
        logic reti;
        acc_in = in_valid && !m_busy;
        reti   = acc_in && in_op == 3'd5;
        m_load = 1'b0;
        if (m_busy) begin
            m_busy = 1'b0;
            m_load = 1'b1;
            m_gie  = 1'b1;
        end else if (acc_in) begin
            case (in_op)
                3'd1: m_rf[in_reg] = m_acc;
                3'd2: m_acc = in_imm;
                3'd3: begin
                    m_z = (m_rf[in_reg] == 8'd0);
                    if (!in_dest) m_acc = m_rf[in_reg];
                end
                3'd4: m_opt = m_acc;
                3'd5: begin
                    m_sp   = m_sp - 3'd1;
                    m_pcv  = m_stk[m_sp];
                    m_busy = 1'b1;
                end
                default: ;
            endcase
        end
        if (push_en && !reti) begin
            m_stk[m_sp] = push_pc;
            m_sp = m_sp + 3'd1;
        end
    endtask

    // Drive one cycle at the falling edge, model it, check at the next one.
    task automatic step(logic v, logic [2:0] op, logic [5:0] r, logic d,
                        logic [7:0] imm, logic pe, logic [9:0] pv, string force_tag);
        string t;
        t = (force_tag != "") ? force_tag : tag_of(v, m_busy, op, d);
        in_valid = v; in_op = op; in_reg = r; in_dest = d; in_imm = imm;
        push_en = pe; push_pc = pv; dbg_addr = r;
        @(posedge clk);
        model_edge();
        @(negedge clk);
        chk(t, "acc", acc_o, m_acc);
        chk(t, "opt", opt_o, m_opt);
        chk(t, "zero", zero_o, m_z);
        chk(t, "gie", gie_o, m_gie);
        chk(t, "busy", busy, m_busy);
        chk(t, "pc_load", pc_load, m_load);
        if (m_load) chk(t, "pc_val", pc_val, m_pcv);
        chk(t, "reg", dbg_data, m_rf[r]);
    endtask

    initial begin
        void'($urandom(32'd1357));
        m_acc = 0; m_opt = 0; m_z = 0; m_gie = 0; m_busy = 0; m_load = 0;
        m_pcv = 0; m_sp = 0;
        for (int i = 0; i < 8; i++) m_stk[i] = 0;
        repeat (3) @(negedge clk);
        // R1: reset values.
        chk("R1", "acc", acc_o, 0);
        chk("R1", "opt", opt_o, 0);
        chk("R1", "zero", zero_o, 0);
        chk("R1", "gie", gie_o, 0);
        chk("R1", "busy", busy, 0);
        chk("R1", "pc_load", pc_load, 0);
        rst_n = 1'b1;
        // Initialise every register: literal then acc to register.
        for (int i = 0; i < 64; i++) begin
            step(1, 3'd2, 6'(i), 0, (i % 5 == 0) ? 8'd0 : 8'(i * 37 + 1), 0, 0, "R3");
            step(1, 3'd1, 6'(i), 0, 0, 0, 0, "R2");
        end
        // R10: fill all stack slots.
        for (int i = 0; i < 8; i++) step(1, 3'd0, 0, 0, 0, 1, 10'(100 + i * 3), "R10");
        // R5: self move of a zero register sets the flag, then a nonzero clears it.
        step(1, 3'd3, 6'd5, 1, 0, 0, 0, "R5");
        step(1, 3'd3, 6'd6, 1, 0, 0, 0, "R5");
        // R4: move a zero register to acc.
        step(1, 3'd3, 6'd10, 0, 0, 0, 0, "R4");
        // R11: nine returns in a row, the ninth wraps to slot 7.
        for (int i = 0; i < 9; i++) begin
            step(1, 3'd5, 0, 0, 0, 0, 0, (i == 8) ? "R11" : "R10");
            step(1, 3'd2, 6'd1, 0, 8'hAA, 0, 0, "R9");
        end
        // R10: push at the same edge as a return is dropped.
        step(1, 3'd0, 0, 0, 0, 1, 10'h155, "R10");
        step(1, 3'd5, 0, 0, 0, 1, 10'h2AA, "R10");
        step(1, 3'd0, 0, 0, 0, 0, 0, "R8");
        step(1, 3'd5, 0, 0, 0, 0, 0, "R10");
        step(1, 3'd0, 0, 0, 0, 0, 0, "R10");
        // R12: idle cycle with a literal on the bus.
        step(0, 3'd2, 6'd3, 0, 8'h5C, 0, 0, "R12");
        // Random mix.
        for (int i = 0; i < 1500; i++) begin
            logic [2:0] op;
            op = 3'($urandom_range(0, 7));
            if (op == 3'd5 && $urandom_range(0, 3) != 0) op = 3'd3;
            step(($urandom_range(0, 9) != 0), op, 6'($urandom_range(0, 63)),
                 1'($urandom_range(0, 1)), 8'($urandom_range(0, 255)),
                 ($urandom_range(0, 5) == 0), 10'($urandom_range(0, 1023)), "");
        end
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    // Watchdog.
    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule